// File: doc/BRIEF.md
# Link Startup Handshake Controller

This block is the receive-side controller that brings one end of a full-duplex serial link from start-up into data mode. It watches a per-frame strobe and the class of each frame received from the far end. From these it drives two transmitter controls (force fill frames, which fill frame to send) and two receiver controls (leave frequency acquisition for phase lock, accept data frames).

The controller has three states: acquisition (0), waiting for the peer (1) and data (2). A state change is taken only when two consecutive frames give the same indication, so a single corrupted frame cannot move the link. A pair of consecutive error frames, or either of two active-low link reset inputs, sends the link back to acquisition and starts a hold-off. The hold-off keeps the link there until 128 consecutive error-free frames have been seen. Usually one link reset is tied to power-on and the other to the transmitter's PLL-locked indication.

Top module: `link_handshake_ctrl`

## Requirements
- R1: While `rst_ni` is low, and in the cycle after either `link_rst_a_ni` or `link_rst_b_ni` is sampled low, the controls are in the acquisition pattern: force_fill=1, fill_sel=0, acq_dis=0, rx_active=0.
- R2: `frame_cls_i` is coded 0 = fill frame 0, 1 = fill frame 1, 2 = data/control, 3 = error. It is only acted on in cycles with `frame_vld_i` high. In other cycles the controls do not change.
- R3: The controls follow the state. Waiting: force_fill=1, fill_sel=1 (fill frame 1), acq_dis=1, rx_active=0. Data: force_fill=0, fill_sel=1, acq_dis=1, rx_active=1. Acquisition is as in R1.
- R4: From acquisition, with the hold-off released, the second of two consecutive fill frames (either type) moves the link to waiting.
- R5: From waiting, the second of two consecutive frames that are each fill frame 1 or data moves the link to data.
- R6: From data, the second of two consecutive fill frame 0 moves the link to acquisition without engaging the hold-off.
- R7: A qualifying frame followed by a non-qualifying one causes no transition. The two-frame count starts afresh after each accepted transition.
- R8: The second of two consecutive error frames, in any state, moves the link to acquisition and engages the hold-off.
- R9: While the hold-off is engaged the link stays in acquisition. Any error frame restarts its count. It releases on the 128th consecutive error-free frame, and the earliest exit is on the next frame, provided the frame before it also qualified.
- R10: A link reset input held low for one or more cycles engages the hold-off, as does a low `rst_ni`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| link_rst_a_ni | input | 1 | Link reset, active low, synchronous (e.g. power-on) |
| link_rst_b_ni | input | 1 | Link reset, active low, synchronous (e.g. transmitter PLL locked) |
| frame_vld_i | input | 1 | One-cycle strobe per received frame |
| frame_cls_i | input | 2 | Class of the received frame (R2 coding) |
| force_fill_o | output | 1 | Transmitter sends fill frames instead of data |
| fill_sel_o | output | 1 | Fill frame type: 0 = fill 0, 1 = fill 1 |
| acq_dis_o | output | 1 | 0 = receiver in frequency acquisition, 1 = phase lock |
| rx_active_o | output | 1 | Receiver accepts data frames |

## Verification
The assertions assume that both link reset inputs are already synchronous to `clk_i`. They also assume that `frame_cls_i` matters only in strobe cycles and that the error-run length keeps its default of two frames. The hold-off tracker in the checker relies on the same assumptions.

The bench drives every input from negative clock edges. It pulses the strobe for exactly one cycle with an idle cycle after it, and changes the class during idle cycles to show that it is ignored. Link resets are applied only between frames.

// File: rtl/lhc_pkg.sv
package lhc_pkg;
  typedef enum logic [1:0] {
    ST_ACQ  = 2'd0,
    ST_WAIT = 2'd1,
    ST_DATA = 2'd2
  } lhc_state_e;

  typedef enum logic [1:0] {
    FC_FILL0 = 2'd0,
    FC_FILL1 = 2'd1,
    FC_DATA  = 2'd2,
    FC_ERR   = 2'd3
  } frame_cls_e;

  typedef struct packed {
    logic force_fill;
    logic fill_sel;
    logic acq_dis;
    logic rx_active;
  } lhc_ctl_t;

  function automatic lhc_ctl_t ctl_of(lhc_state_e s);
    lhc_ctl_t c;
    unique case (s)
      ST_WAIT: c = '{force_fill: 1'b1, fill_sel: 1'b1, acq_dis: 1'b1, rx_active: 1'b0};
      ST_DATA: c = '{force_fill: 1'b0, fill_sel: 1'b1, acq_dis: 1'b1, rx_active: 1'b1};
      default: c = '{force_fill: 1'b1, fill_sel: 1'b0, acq_dis: 1'b0, rx_active: 1'b0};
    endcase
    return c;
  endfunction

  function automatic lhc_state_e next_of(lhc_state_e s);
    unique case (s)
      ST_ACQ:  return ST_WAIT;
      ST_WAIT: return ST_DATA;
      default: return ST_ACQ;
    endcase
  endfunction
endpackage

// File: rtl/lhc_run_ctr.sv
// Counts consecutive hits on strobed steps; full_o marks the step that completes the run.
module lhc_run_ctr #(
  parameter int unsigned RUN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  input  logic hit_i,
  output logic full_o
);
  localparam int unsigned RW = (RUN > 1) ? $clog2(RUN) : 1;
  localparam logic [RW-1:0] TOP = RW'(RUN - 1);

  logic [RW-1:0] run_q;

  assign full_o = step_i & hit_i & (run_q == TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
    end else if (clr_i) begin
      run_q <= '0;
    end else if (step_i) begin
      if (!hit_i)           run_q <= '0;
      else if (run_q != TOP) run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/lhc_holdoff.sv
// Error hold-off: armed by resets or an error run, released after HOLD error-free frames.
module lhc_holdoff #(
  parameter int unsigned HOLD = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic step_i,
  input  logic bad_i,
  output logic hold_o
);
  localparam int unsigned CW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic          hold_q;
  logic [CW-1:0] cnt_q;

  assign hold_o = hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else if (arm_i) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else if (step_i && hold_q) begin
      if (bad_i) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        hold_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/link_handshake_ctrl.sv
module link_handshake_ctrl
  import lhc_pkg::*;
#(
  parameter int unsigned CONFIRM_FRAMES = 2,
  parameter int unsigned ERR_RUN        = 2,
  parameter int unsigned HOLD_FRAMES    = 128
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       link_rst_a_ni,
  input  logic       link_rst_b_ni,
  input  logic       frame_vld_i,
  input  logic [1:0] frame_cls_i,
  output logic       force_fill_o,
  output logic       fill_sel_o,
  output logic       acq_dis_o,
  output logic       rx_active_o
);
  lhc_state_e state_q;
  frame_cls_e cls;
  lhc_ctl_t   ctl;
  logic link_rst, is_bad, ind, deb_full, bad_run, hold, take;

  assign cls      = frame_cls_e'(frame_cls_i);
  assign link_rst = ~link_rst_a_ni | ~link_rst_b_ni;
  assign is_bad   = (cls == FC_ERR);

  // per-state indication that the peer has advanced
  always_comb begin
    unique case (state_q)
      ST_ACQ:  ind = (cls == FC_FILL0) | (cls == FC_FILL1);
      ST_WAIT: ind = (cls == FC_FILL1) | (cls == FC_DATA);
      default: ind = (cls == FC_FILL0);
    endcase
  end

  assign take = deb_full & ~((state_q == ST_ACQ) & hold);

  lhc_run_ctr #(.RUN(CONFIRM_FRAMES)) u_confirm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (link_rst | bad_run | take),
    .step_i(frame_vld_i),
    .hit_i (ind),
    .full_o(deb_full)
  );

  lhc_run_ctr #(.RUN(ERR_RUN)) u_err_run (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (link_rst),
    .step_i(frame_vld_i),
    .hit_i (is_bad),
    .full_o(bad_run)
  );

  lhc_holdoff #(.HOLD(HOLD_FRAMES)) u_holdoff (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .arm_i (link_rst | bad_run),
    .step_i(frame_vld_i),
    .bad_i (is_bad),
    .hold_o(hold)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 state_q <= ST_ACQ;
    else if (link_rst || bad_run) state_q <= ST_ACQ;
    else if (take)               state_q <= next_of(state_q);
  end

  assign ctl          = ctl_of(state_q);
  assign force_fill_o = ctl.force_fill;
  assign fill_sel_o   = ctl.fill_sel;
  assign acq_dis_o    = ctl.acq_dis;
  assign rx_active_o  = ctl.rx_active;
endmodule

// File: rtl/lhc_checker.sv
module lhc_checker #(
  parameter int unsigned HOLD_FRAMES = 128
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       link_rst_a_ni,
  input logic       link_rst_b_ni,
  input logic       frame_vld_i,
  input logic [1:0] frame_cls_i,
  input logic       force_fill_o,
  input logic       fill_sel_o,
  input logic       acq_dis_o,
  input logic       rx_active_o
);
  localparam int unsigned MW = $clog2(HOLD_FRAMES) + 1;

  logic [3:0]    ctl;
  logic          lrst, err_f, prev_err_q, mlock_q;
  logic [MW-1:0] mcnt_q;

  assign ctl   = {force_fill_o, fill_sel_o, acq_dis_o, rx_active_o};
  assign lrst  = ~link_rst_a_ni | ~link_rst_b_ni;
  assign err_f = frame_vld_i & (frame_cls_i == 2'd3);

  // independent hold-off tracker
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_err_q <= 1'b0;
      mlock_q    <= 1'b1;
      mcnt_q     <= '0;
    end else if (lrst) begin
      prev_err_q <= 1'b0;
      mlock_q    <= 1'b1;
      mcnt_q     <= '0;
    end else if (frame_vld_i) begin
      prev_err_q <= err_f;
      if (err_f && prev_err_q) begin
        mlock_q <= 1'b1;
        mcnt_q  <= '0;
      end else if (mlock_q) begin
        if (err_f) mcnt_q <= '0;
        else if (mcnt_q == MW'(HOLD_FRAMES - 1)) begin
          mlock_q <= 1'b0;
          mcnt_q  <= '0;
        end else mcnt_q <= mcnt_q + 1'b1;
      end
    end
  end

  a_r1_link_rst_acq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lrst |=> (ctl == 4'b1000));

  a_r2_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_vld_i && !lrst) |=> $stable(ctl));

  a_r4_no_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acq_dis_o |=> !rx_active_o);

  a_r5_data_from_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_active_o) |-> $past(force_fill_o && fill_sel_o));

  a_r8_err_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_f && prev_err_q) |=> (ctl == 4'b1000));

  a_r9_hold_acq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mlock_q && !acq_dis_o) |=> !acq_dis_o);
endmodule

bind link_handshake_ctrl lhc_checker #(.HOLD_FRAMES(HOLD_FRAMES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .link_rst_a_ni(link_rst_a_ni),
  .link_rst_b_ni(link_rst_b_ni),
  .frame_vld_i  (frame_vld_i),
  .frame_cls_i  (frame_cls_i),
  .force_fill_o (force_fill_o),
  .fill_sel_o   (fill_sel_o),
  .acq_dis_o    (acq_dis_o),
  .rx_active_o  (rx_active_o)
);

// File: tb/sim_link_handshake_ctrl.sv
module sim_link_handshake_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 128;
  localparam int WD_LIMIT = 200000;

  logic clk = 1'b0, rst_n = 1'b0, lra_n = 1'b1, lrb_n = 1'b1, vld = 1'b0;
  logic [1:0] cls = 2'd0;
  logic ff, fs, ad, ra;

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  // reference model, written from the requirements
  int m_st = 0, m_run = 0, m_cnt = 0;
  bit m_lock = 1, m_pbad = 0;
  string m_tag = "R3";

  always #(CLK_PERIOD/2) clk = ~clk;

  link_handshake_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .link_rst_a_ni(lra_n), .link_rst_b_ni(lrb_n),
    .frame_vld_i(vld), .frame_cls_i(cls),
    .force_fill_o(ff), .fill_sel_o(fs), .acq_dis_o(ad), .rx_active_o(ra)
  );

  function automatic logic [3:0] exp_ctl(int st);
    case (st)
      1:       return 4'b1110;
      2:       return 4'b0111;
      default: return 4'b1000;
    endcase
  endfunction

  task automatic chk(string tag, logic [3:0] exp);
    logic [3:0] act;
    act = {ff, fs, ad, ra};
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: controls=%b expected=%b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(int c);
    bit bad, ind, lock_old;
    bad = (c == 3);
    lock_old = m_lock;
    if (bad && m_pbad) begin
      m_st = 0; m_lock = 1; m_cnt = 0; m_run = 0; m_tag = "R8";
    end else begin
      ind = (m_st == 0) ? (c == 0 || c == 1) : (m_st == 1) ? (c == 1 || c == 2) : (c == 0);
      m_tag = "R3";
      if (ind && m_run == 1) begin
        if (m_st == 0 && lock_old) m_tag = "R9";
        else begin
          m_tag = (m_st == 0) ? "R4" : (m_st == 1) ? "R5" : "R6";
          m_st = (m_st + 1) % 3;
          m_run = 0;
        end
      end else m_run = ind ? 1 : 0;
      if (m_lock) begin
        if (bad) m_cnt = 0;
        else if (m_cnt == HOLD - 1) begin m_lock = 0; m_cnt = 0; end
        else m_cnt++;
      end
    end
    m_pbad = bad;
  endtask

  task automatic frame(int c);
    @(negedge clk); vld = 1'b1; cls = 2'(c);
    @(negedge clk); vld = 1'b0;
    model_step(c);
    chk(m_tag, exp_ctl(m_st));
  endtask

  task automatic frames(int c, int n);
    for (int i = 0; i < n; i++) frame(c);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cls = 2'(i % 4);
      chk("R2", exp_ctl(m_st));
    end
  endtask

  task automatic link_reset(bit which, int n);
    @(negedge clk);
    if (which) lrb_n = 1'b0; else lra_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); chk("R10", 4'b1000);
    end
    lra_n = 1'b1; lrb_n = 1'b1;
    m_st = 0; m_lock = 1; m_cnt = 0; m_run = 0; m_pbad = 0;
    @(negedge clk); chk("R1", 4'b1000);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WD_LIMIT && !done) begin
      n_fail++;
      $display("FAIL watchdog: cycles=%0d expected<%0d", cyc, WD_LIMIT);
      $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    int c;
    repeat (3) @(negedge clk);
    chk("R1", 4'b1000);
    rst_n = 1'b1;
    @(negedge clk); chk("R1", 4'b1000);

    // start-up hold-off: 128 fill frames keep acquisition, 129th leaves it
    frames(0, HOLD);
    chk("R9", 4'b1000);
    frame(0);
    chk("R4", 4'b1110);

    // waiting: broken pair, then fill1+data
    frame(2); frame(0);
    chk("R7", 4'b1110);
    frame(1); frame(2);
    chk("R5", 4'b0111);
    idle(6);

    // data: broken pair then fill0 pair returns without hold-off
    frame(0); frame(2); frame(0);
    chk("R7", 4'b0111);
    frame(0);
    chk("R6", 4'b1000);
    frame(1); frame(1);
    chk("R4", 4'b1110);
    frames(1, 2);
    chk("R5", 4'b0111);

    // error pair from data, hold-off restarted by a later error
    frame(3);
    chk("R8", 4'b0111);
    frame(3);
    chk("R8", 4'b1000);
    frames(0, 60);
    frame(3);
    frames(1, HOLD);
    chk("R9", 4'b1000);
    frame(1);
    chk("R9", 4'b1110);

    // link resets re-engage hold-off
    link_reset(1'b1, 3);
    frames(0, HOLD);
    chk("R10", 4'b1000);
    frame(1);
    chk("R10", 4'b1110);
    link_reset(1'b0, 1);
    frames(1, HOLD + 1);
    chk("R10", 4'b1110);
    idle(4);

    // sweep: pseudo-random classes, rare errors, periodic error pairs and resets
    lfsr = 16'hACE1;
    for (int k = 0; k < 5000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (k % 900 == 450) begin frame(3); frame(3); end
      else if (k % 1300 == 1299) link_reset(k[0], 2);
      else begin
        c = (lfsr[7:0] == 8'd0) ? 3 : (int'(lfsr[13:8]) % 3);
        frame(c);
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule